// File: doc/BRIEF.md
# Flag-Setting Multiply Unit

This block multiplies two operands of byte, halfword or word size, either as unsigned numbers or as two's-complement numbers, and reports zero, sign and overflow flags for the product. A caller presents the operands, a size code and the mode selects together with a one-cycle start strobe. The unit then runs a shift-add engine whose length depends on the operand size. After that it presents the result and flags for one cycle with a done pulse. The result ports and flags keep their values until the next operation completes.

In the normal mode the product is cut down to the operand width, and overflow reports any lost upper bits. In the extended mode both operands are treated as full words and the whole double-width product is returned. The lower word comes out on one port and the upper word on another, for a caller that writes them into a register pair. Operand fetch and writeback stay with the caller.

Top module: `mul_flag_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `result_lo`, `result_hi` and all three flags are zero.
- R2: A start seen while `busy` is low is accepted. `busy` is high from the next cycle on. `done` pulses for exactly one cycle, 2·w+1 cycles after the accepting edge, where w is the effective operand width. `busy` falls in that same cycle.
- R3: A start seen while `busy` is high is ignored. It changes neither the timing nor the result of the operation in progress. A start held high through the `done` cycle is accepted at the next edge.
- R4: In normal mode `result_lo` holds the low w bits of the double-width product, zero-extended to the port width, and `result_hi` is zero. Operand bits above w have no effect.
- R5: With `signed_mode` high, both operands are sign-extended from bit w-1 before multiplying. With it low, they are zero-extended.
- R6: In normal mode `flag_z` is set when the truncated result is zero, and `flag_s` equals bit w-1 of the truncated result.
- R7: In normal mode `flag_ov` is set when any of bits w to 2w-1 of the product is one. This applies in signed mode too, so a negative signed product sets it.
- R8: With `ext_mode` high, the operands are full words whatever the size code. `result_lo` is product bits W-1..0 and `result_hi` is bits 2W-1..W.
- R9: In extended mode `flag_s` is bit W-1 of `result_hi`, and `flag_z` is set only when both words are zero.
- R10: An extended-mode operation leaves `flag_ov` at its previous value.
- R11: Outputs and flags change only in a `done` cycle and hold otherwise.
- R12: The size code is 0 for byte (W/4 bits), 1 for halfword (W/2 bits), and 2 or 3 for word (W bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| size_sel | input | 2 | Operand size code |
| signed_mode | input | 1 | 1 = two's-complement operands |
| ext_mode | input | 1 | 1 = full double-width product |
| opnd_a | input | W | Multiplicand |
| opnd_b | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| result_lo | output | W | Truncated result or low product word |
| result_hi | output | W | High product word (zero in normal mode) |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_ov | output | 1 | Overflow flag |

## Verification
The collision that matters is a new start arriving in the cycle when the previous result is being delivered, that is, in the same cycle as `done`. The bench holds start high across a whole operation, with fresh operands behind it. The reference model then demands that the second operation is accepted only at the edge after `done`, so the two results do not overlap or merge. A start pulse in the middle of a run is also applied, and the model requires it to leave the running operation's timing and outputs untouched.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } mfu_size_e;
endpackage

// File: rtl/mfu_operand_prep.sv
module mfu_operand_prep #(
  parameter int W  = 32,
  parameter int CW = $clog2(2 * W + 1)
) (
  input  logic [1:0]     size_sel,
  input  logic           signed_mode,
  input  logic           ext_mode,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [1:0]     size_eff,
  output logic [2*W-1:0] a_wide,
  output logic [2*W-1:0] b_wide,
  output logic [CW-1:0]  iter_count
);
  import mfu_pkg::*;
  localparam int BW = W / 4;
  localparam int HW = W / 2;

  function automatic logic [2*W-1:0] widen(input logic [W-1:0] v,
                                           input logic [1:0] sz,
                                           input logic sgn);
    logic [2*W-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(2*W-BW){sgn & v[BW-1]}}, v[BW-1:0]};
      SZ_HALF: r = {{(2*W-HW){sgn & v[HW-1]}}, v[HW-1:0]};
      default: r = {{W{sgn & v[W-1]}}, v};
    endcase
    return r;
  endfunction

  always_comb begin
    size_eff = ext_mode ? SZ_WORD : size_sel;
    a_wide   = widen(a_in, size_eff, signed_mode);
    b_wide   = widen(b_in, size_eff, signed_mode);
    case (size_eff)
      SZ_BYTE: iter_count = CW'(2 * BW);
      SZ_HALF: iter_count = CW'(2 * HW);
      default: iter_count = CW'(2 * W);
    endcase
  end
endmodule

// File: rtl/mfu_shift_add_core.sv
module mfu_shift_add_core #(
  parameter int W  = 32,
  parameter int CW = $clog2(2 * W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [2*W-1:0] a_wide,
  input  logic [2*W-1:0] b_wide,
  input  logic [CW-1:0]  iter_count,
  output logic [2*W-1:0] product,
  output logic           finished
);
  logic [2*W-1:0] mcand, mplier, acc;
  logic [CW-1:0]  remain;
  logic           running;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand    <= '0;
      mplier   <= '0;
      acc      <= '0;
      remain   <= '0;
      running  <= 1'b0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (load) begin
        mcand   <= a_wide;
        mplier  <= b_wide;
        acc     <= '0;
        remain  <= iter_count;
        running <= 1'b1;
      end else if (running) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        remain <= remain - 1'b1;
        if (remain == CW'(1)) begin
          running  <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign product = acc;
endmodule

// File: rtl/mfu_flag_gen.sv
module mfu_flag_gen #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] product,
  input  logic [1:0]     size_eff,
  input  logic           ext_mode,
  output logic [W-1:0]   lo_word,
  output logic [W-1:0]   hi_word,
  output logic           z_new,
  output logic           s_new,
  output logic           ov_new
);
  import mfu_pkg::*;
  localparam int BW = W / 4;
  localparam int HW = W / 2;

  always_comb begin
    hi_word = '0;
    ov_new  = 1'b0;
    if (ext_mode) begin
      lo_word = product[W-1:0];
      hi_word = product[2*W-1:W];
      s_new   = product[2*W-1];
      z_new   = (product == '0);
    end else begin
      case (size_eff)
        SZ_BYTE: begin
          lo_word = {{(W-BW){1'b0}}, product[BW-1:0]};
          s_new   = product[BW-1];
          ov_new  = |product[2*BW-1:BW];
        end
        SZ_HALF: begin
          lo_word = {{(W-HW){1'b0}}, product[HW-1:0]};
          s_new   = product[HW-1];
          ov_new  = |product[2*HW-1:HW];
        end
        default: begin
          lo_word = product[W-1:0];
          s_new   = product[W-1];
          ov_new  = |product[2*W-1:W];
        end
      endcase
      z_new = (lo_word == '0);
    end
  end
endmodule

// File: rtl/mul_flag_unit.sv
module mul_flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   size_sel,
  input  logic         signed_mode,
  input  logic         ext_mode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result_lo,
  output logic [W-1:0] result_hi,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_ov
);
  localparam int CW = $clog2(2 * W + 1);

  logic           accept;
  logic [1:0]     size_eff, size_q;
  logic           ext_q;
  logic [2*W-1:0] a_wide, b_wide, product;
  logic [CW-1:0]  iter_count;
  logic           finished;
  logic [W-1:0]   lo_word, hi_word;
  logic           z_new, s_new, ov_new;

  assign accept = start & ~busy;

  mfu_operand_prep #(.W(W), .CW(CW)) u_prep (
    .size_sel(size_sel), .signed_mode(signed_mode), .ext_mode(ext_mode),
    .a_in(opnd_a), .b_in(opnd_b), .size_eff(size_eff),
    .a_wide(a_wide), .b_wide(b_wide), .iter_count(iter_count)
  );

  mfu_shift_add_core #(.W(W), .CW(CW)) u_core (
    .clk(clk), .rst(rst), .load(accept), .a_wide(a_wide), .b_wide(b_wide),
    .iter_count(iter_count), .product(product), .finished(finished)
  );

  mfu_flag_gen #(.W(W)) u_flags (
    .product(product), .size_eff(size_q), .ext_mode(ext_q),
    .lo_word(lo_word), .hi_word(hi_word),
    .z_new(z_new), .s_new(s_new), .ov_new(ov_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      size_q    <= '0;
      ext_q     <= 1'b0;
      result_lo <= '0;
      result_hi <= '0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
      flag_ov   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        size_q <= size_eff;
        ext_q  <= ext_mode;
      end else if (finished) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        result_lo <= lo_word;
        result_hi <= hi_word;
        flag_z    <= z_new;
        flag_s    <= s_new;
        if (!ext_q) flag_ov <= ov_new;
      end
    end
  end
endmodule

// File: rtl/mul_flag_unit_chk.sv
module mul_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         ext_mode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result_lo,
  input logic [W-1:0] result_hi,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_ov
);
  logic past_ok;
  logic ext_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      ext_cap <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (start && !busy) ext_cap <= ext_mode;
    end
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_output_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> ($stable(result_lo) && $stable(result_hi) &&
                            $stable(flag_z) && $stable(flag_s) && $stable(flag_ov)));
  assert_hi_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !ext_cap) |-> (result_hi == '0));
  assert_ext_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (done && ext_cap) |-> (flag_z == ((result_lo == '0) && (result_hi == '0))));
  assert_ext_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (done && ext_cap) |-> (flag_s == result_hi[W-1]));
  assert_ov_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && done && ext_cap) |-> $stable(flag_ov));
endmodule

bind mul_flag_unit mul_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ext_mode(ext_mode), .busy(busy),
  .done(done), .result_lo(result_lo), .result_hi(result_hi),
  .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov)
);

// File: tb/mul_flag_unit_test.sv
module mul_flag_unit_test;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic signed_mode = 1'b0;
  logic ext_mode = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic busy, done, flag_z, flag_s, flag_ov;
  logic [W-1:0] result_lo, result_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_flag_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .signed_mode(signed_mode), .ext_mode(ext_mode), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .busy(busy), .done(done), .result_lo(result_lo),
    .result_hi(result_hi), .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov)
  );

  // Behavioural reference model
  bit m_busy, m_done, m_ext, p_ext, in_reset_phase;
  int m_cnt;
  logic [W-1:0] e_lo, e_hi, p_lo, p_hi;
  bit e_z, e_s, e_ov, p_z, p_s, p_ov;
  int n_vec = 0, n_bad = 0, cycles = 0;

  task automatic predict();
    int w;
    logic [63:0] ea, eb, prod, mask;
    // R12: code 0 byte, 1 half, 2/3 word; R8: extended forces word
    w = ext_mode ? W : (size_sel == 2'd0 ? W/4 : size_sel == 2'd1 ? W/2 : W);
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    ea = opnd_a & mask;
    eb = opnd_b & mask;
    if (signed_mode) begin // R5
      if (ea[w-1]) ea = ea | ~mask;
      if (eb[w-1]) eb = eb | ~mask;
    end
    prod = ea * eb;
    p_ext = ext_mode;
    if (ext_mode) begin
      p_lo = prod[31:0];
      p_hi = prod[63:32];
      p_z  = (prod == 0);
      p_s  = prod[63];
    end else begin
      p_lo = W'(prod & mask);
      p_hi = '0;
      p_z  = (p_lo == 0);
      p_s  = prod[w-1];
      p_ov = ((prod >> w) & mask) != 0;
    end
    m_cnt = 2 * w + 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    m_done = 0;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_ext = 0;
      e_lo = '0; e_hi = '0; e_z = 0; e_s = 0; e_ov = 0;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        m_busy = 0; m_done = 1;
        e_lo = p_lo; e_hi = p_hi; e_z = p_z; e_s = p_s; m_ext = p_ext;
        if (!p_ext) e_ov = p_ov; // R10
      end else m_cnt--;
    end else if (start) begin
      predict();
      m_busy = 1;
    end
  end

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Compared on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      n_vec++;
      if (in_reset_phase) begin
        chk("R1", "busy", W'(busy), W'(0));
        chk("R1", "lo", result_lo, '0);
        chk("R1", "flags", W'({flag_z, flag_s, flag_ov, done}), W'(0));
      end else begin
        chk("R2", "done", W'(done), W'(m_done));
        chk("R3", "busy", W'(busy), W'(m_busy));
        chk(m_ext ? "R8" : "R4", "result_lo", result_lo, e_lo);
        chk(m_ext ? "R8" : "R4", "result_hi", result_hi, e_hi);
        chk(m_ext ? "R9" : "R6", "flag_z", W'(flag_z), W'(e_z));
        chk(m_ext ? "R9" : "R6", "flag_s", W'(flag_s), W'(e_s));
        chk(m_ext ? "R10" : "R7", "flag_ov", W'(flag_ov), W'(e_ov));
        // R11: outputs compared in all cycles, so holding is checked too
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b,
                    input logic [1:0] sz, input bit sg, input bit ex);
    @(negedge clk);
    opnd_a = a; opnd_b = b; size_sel = sz; signed_mode = sg; ext_mode = ex;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opnd_a = '1; opnd_b = '1;
    wait_idle();
  endtask

  task automatic stimulus();
    in_reset_phase = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk); // R1 reset state
    in_reset_phase = 0;
    op(32'h12, 32'h34, 2'd0, 0, 0);            // R4 R7 byte overflow
    op(32'h3, 32'h5, 2'd0, 0, 0);              // R7 no overflow
    op(32'hFF, 32'h01, 2'd0, 1, 0);            // R5 R7 negative signed sets OV
    op(32'hABCD0003, 32'h77770005, 2'd0, 0, 0); // R4 upper bits ignored
    op(32'hFFFD, 32'hFFFC, 2'd1, 1, 0);        // R5 -3*-4 half
    op(32'h8000, 32'h2, 2'd1, 0, 0);           // R6 zero result with OV
    op(32'h7FFFFFFF, 32'h2, 2'd2, 1, 0);       // word signed
    op(32'h00010000, 32'h00010000, 2'd3, 0, 0); // R12 code 3 is word
    op(32'hFFFFFFFF, 32'hFFFFFFFF, 2'd0, 0, 1); // R8 R10 ext unsigned, OV kept 1
    op(32'h2, 32'h3, 2'd0, 0, 0);              // OV back to 0
    op(32'hFFFFFFFF, 32'hFFFFFFFF, 2'd1, 1, 1); // R8 ext signed -1*-1
    op(32'h80000000, 32'h2, 2'd0, 1, 1);       // R9 negative high word
    op(32'h0, 32'h12345678, 2'd2, 0, 1);       // R9 both words zero
    // R3: start pulse in mid-run is ignored
    @(negedge clk);
    opnd_a = 32'h11; opnd_b = 32'h22; size_sel = 2'd0; signed_mode = 0; ext_mode = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    opnd_a = 32'h99; opnd_b = 32'h99; size_sel = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R3: start held through the done cycle, back-to-back
    @(negedge clk);
    opnd_a = 32'h1234; opnd_b = 32'h0101; size_sel = 2'd1; signed_mode = 0; ext_mode = 0;
    start = 1'b1;
    @(negedge clk);
    opnd_a = 32'hC0; opnd_b = 32'h40; size_sel = 2'd0; signed_mode = 1;
    while (!m_done) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule